// File: doc/BRIEF.md
# Multi-Lane Serial Audio Port

This block is the digital audio port of a synthesiser. It derives a bit clock and a word-select line from the core clock. It shifts out two stereo output lanes, four channels in all, and shifts in one stereo input lane. A frame holds two 32-bit slots per lane and takes 64 bit clocks of 16 core clocks each. One frame is therefore 1024 core clocks, which is one sample period.

All four output samples are captured in the same core cycle, once per frame, together with the slot format, the output width and a control word. Each capture happens on the cycle in which `tx_load` is high. Two slot layouts are supported. The first is the common two-channel layout, with the MSB one bit after the word-select change. The second is right-justified, with the LSB in the last bit of the slot. In the right-justified layout, the bits ahead of the sample carry the control word on lane 0 and the sign on lane 1. The two received 16-bit samples are presented with a one-cycle valid pulse at each frame boundary.

Top module: `serial_audio_port`

## Requirements
- R1: While reset is held, `bclk`, `ws`, `sd_out` and `rx_valid` are 0 and both received samples are 0. The first frame after reset sends all-zero data in the standard layout with 16-bit width.
- R2: `bclk` is low for 8 core clocks and then high for 8, with a period of 16. `tx_load` is a one-cycle pulse every 1024 core clocks, which is 64 bit clocks.
- R3: `sd_out` and `ws` change only in the cycle in which `bclk` falls, 8 core clocks before the next rising edge.
- R4: With `fmt_rj`=0, `ws` is 0 for the left slot (frame bits 0-31) and 1 for the right slot. The sample MSB is at slot bit 1 and its W bits follow MSB first. All other slot bits are 0 on both lanes.
- R5: With `fmt_rj`=1, `ws` is 1 for the left slot and 0 for the right slot, and the sample LSB is slot bit 31. The 32-W bits ahead of the sample carry `ctrl_word` MSB first on lane 0, so `ctrl_word[15]` is at slot bit 0. On lane 1 they carry copies of bit 19 of the sample field.
- R6: `width_sel` sets W: 0 gives 16, 1 gives 18, and 2 or 3 gives 20. The W most significant bits of each 20-bit sample field are sent.
- R7: Samples, `fmt_rj`, `width_sel` and `ctrl_word` are captured on the rising edge at which `tx_load` is 1. They apply to the whole of the next frame. Changes at any other time have no effect on the frame in progress.
- R8: The channels map as follows: `tx_samples[19:0]` is lane 0 left, `[39:20]` is lane 0 right, `[59:40]` is lane 1 left, and `[79:60]` is lane 1 right. Lane 0 appears on `sd_out[0]`.
- R9: `sd_in` is sampled at each `bclk` rising edge. In the standard layout the 16 sample bits are slot bits 1-16, MSB first. In the right-justified layout they are slot bits 16-31. All other input bits are ignored.
- R10: `rx_valid` is a one-cycle pulse in the cycle after `tx_load`. At that pulse, `rx_left` and `rx_right` hold the samples of the frame that just ended, and they keep those values until the next pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fmt_rj | input | 1 | Slot layout: 0 standard, 1 right-justified |
| width_sel | input | 2 | Output sample width select |
| ctrl_word | input | 16 | Control bits for the lane 0 right-justified prefix |
| tx_samples | input | 80 | Four 20-bit output samples |
| sd_in | input | 1 | Serial input lane |
| bclk | output | 1 | Bit clock |
| ws | output | 1 | Word select |
| sd_out | output | 2 | Serial output lanes |
| tx_load | output | 1 | Capture strobe for the output samples and settings |
| rx_left | output | 16 | Received left sample |
| rx_right | output | 16 | Received right sample |
| rx_valid | output | 1 | Received samples updated |

## Verification
The hardest condition to reach is a setting or sample that changes in the middle of a frame. The design must ignore it until the next capture strobe, while the frame in progress keeps the layout and width it started with. The driver therefore applies a valid vector just before each capture. A few hundred cycles later it replaces every input with its inverse, including a flipped layout and width. Any capture that is early or leaks would then corrupt the expected bit stream of that frame. The input lane drives toggling values on the slot bits outside the sample window, which shows that those bits are ignored.

// File: rtl/sap_pkg.sv
package sap_pkg;

  typedef enum logic {
    FMT_STD = 1'b0,
    FMT_RJ  = 1'b1
  } sap_fmt_e;

  // Output sample width for a given select code: two shorter steps, then full width.
  function automatic int sap_width(logic [1:0] sel, int max_w);
    case (sel)
      2'd0:    return max_w - 4;
      2'd1:    return max_w - 2;
      default: return max_w;
    endcase
  endfunction

endpackage

// File: rtl/sap_timing.sv
module sap_timing #(
  parameter int BIT_CLKS  = 16,
  parameter int SLOT_BITS = 32,
  localparam int FRAME    = 2 * SLOT_BITS * BIT_CLKS,
  localparam int FRAME_W  = $clog2(FRAME)
) (
  input  logic               clk,
  input  logic               rst_n,
  output logic [FRAME_W-1:0] cnt,
  output logic               last
);

  logic [FRAME_W-1:0] cnt_q, cnt_n;

  assign last = (cnt_q == FRAME_W'(FRAME - 1));

  always_comb begin
    cnt_n = last ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/sap_tx_lane.sv
module sap_tx_lane
  import sap_pkg::*;
#(
  parameter int SMP_W     = 20,
  parameter int SLOT_BITS = 32,
  parameter int CTRL_W    = 16,
  parameter bit USE_CTRL  = 1'b0,
  localparam int POS_W    = $clog2(SLOT_BITS),
  localparam int IDX_W    = $clog2(SMP_W),
  localparam int CIDX_W   = $clog2(CTRL_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic [POS_W-1:0]  pos,
  input  logic              right,
  input  sap_fmt_e          fmt,
  input  logic [1:0]        wsel,
  input  logic [SMP_W-1:0]  smp_l,
  input  logic [SMP_W-1:0]  smp_r,
  input  logic [CTRL_W-1:0] ctrl,
  output logic              sd
);

  logic [SMP_W-1:0] smp;
  logic             bit_n, sd_q;
  int               p, wv, start;

  assign smp = right ? smp_r : smp_l;

  always_comb begin
    p     = int'(pos);
    wv    = sap_width(wsel, SMP_W);
    start = SLOT_BITS - wv;
    bit_n = 1'b0;
    if (fmt == FMT_STD) begin
      if (p >= 1 && p <= wv) bit_n = smp[IDX_W'(SMP_W - p)];
    end else begin
      if (p >= start)        bit_n = smp[IDX_W'(SMP_W - 1 - (p - start))];
      else if (USE_CTRL)     bit_n = ctrl[CIDX_W'(CTRL_W - 1 - p)];
      else                   bit_n = smp[SMP_W-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sd_q <= 1'b0;
    else if (bit_en) sd_q <= bit_n;
  end

  assign sd = sd_q;

endmodule

// File: rtl/sap_rx.sv
module sap_rx
  import sap_pkg::*;
#(
  parameter int IN_W      = 16,
  parameter int SLOT_BITS = 32,
  localparam int POS_W    = $clog2(SLOT_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_en,
  input  logic [POS_W-1:0] pos,
  input  logic             right,
  input  sap_fmt_e         fmt,
  input  logic             sd_in,
  input  logic             frame_end,
  output logic [IN_W-1:0]  rx_l,
  output logic [IN_W-1:0]  rx_r,
  output logic             valid
);

  logic [IN_W-1:0] sh_l_q, sh_r_q, sh_l_n, sh_r_n;
  logic [IN_W-1:0] out_l_q, out_r_q;
  logic            valid_q, in_win;
  int              p;

  always_comb begin
    p      = int'(pos);
    in_win = (fmt == FMT_STD) ? (p >= 1 && p <= IN_W) : (p >= SLOT_BITS - IN_W);
    sh_l_n = sh_l_q;
    sh_r_n = sh_r_q;
    if (smp_en && in_win) begin
      if (right) sh_r_n = {sh_r_q[IN_W-2:0], sd_in};
      else       sh_l_n = {sh_l_q[IN_W-2:0], sd_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_l_q  <= '0;
      sh_r_q  <= '0;
      out_l_q <= '0;
      out_r_q <= '0;
      valid_q <= 1'b0;
    end else begin
      sh_l_q  <= sh_l_n;
      sh_r_q  <= sh_r_n;
      valid_q <= frame_end;
      if (frame_end) begin
        out_l_q <= sh_l_q;
        out_r_q <= sh_r_q;
      end
    end
  end

  assign rx_l  = out_l_q;
  assign rx_r  = out_r_q;
  assign valid = valid_q;

endmodule

// File: rtl/serial_audio_port.sv
module serial_audio_port
  import sap_pkg::*;
#(
  parameter int SMP_W     = 20,
  parameter int IN_W      = 16,
  parameter int SLOT_BITS = 32,
  parameter int BIT_CLKS  = 16,
  parameter int CTRL_W    = 16,
  localparam int LANES    = 2,
  localparam int PH_W     = $clog2(BIT_CLKS),
  localparam int POS_W    = $clog2(SLOT_BITS),
  localparam int FRAME_W  = PH_W + POS_W + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     fmt_rj,
  input  logic [1:0]               width_sel,
  input  logic [CTRL_W-1:0]        ctrl_word,
  input  logic [2*LANES*SMP_W-1:0] tx_samples,
  input  logic                     sd_in,
  output logic                     bclk,
  output logic                     ws,
  output logic [LANES-1:0]         sd_out,
  output logic                     tx_load,
  output logic [IN_W-1:0]          rx_left,
  output logic [IN_W-1:0]          rx_right,
  output logic                     rx_valid
);

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rs_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  logic [FRAME_W-1:0] cnt;
  logic               last;

  sap_timing #(.BIT_CLKS(BIT_CLKS), .SLOT_BITS(SLOT_BITS)) u_tim (
    .clk(clk), .rst_n(rst_i_n), .cnt(cnt), .last(last)
  );

  logic [PH_W-1:0]  phase;
  logic [POS_W-1:0] pos;
  logic             right, bit_en, mid_en;

  assign phase  = cnt[PH_W-1:0];
  assign pos    = cnt[PH_W +: POS_W];
  assign right  = cnt[FRAME_W-1];
  assign bit_en = (phase == '0);
  assign mid_en = (phase == PH_W'(BIT_CLKS / 2));

  // Frame settings, captured together at the frame boundary.
  sap_fmt_e                 fmt_q, fmt_n;
  logic [1:0]               wsel_q, wsel_n;
  logic [CTRL_W-1:0]        ctrl_q, ctrl_n;
  logic [2*LANES*SMP_W-1:0] smp_q, smp_n;

  always_comb begin
    fmt_n  = fmt_q;
    wsel_n = wsel_q;
    ctrl_n = ctrl_q;
    smp_n  = smp_q;
    if (last) begin
      fmt_n  = sap_fmt_e'(fmt_rj);
      wsel_n = width_sel;
      ctrl_n = ctrl_word;
      smp_n  = tx_samples;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      fmt_q  <= FMT_STD;
      wsel_q <= 2'd0;
      ctrl_q <= '0;
      smp_q  <= '0;
    end else begin
      fmt_q  <= fmt_n;
      wsel_q <= wsel_n;
      ctrl_q <= ctrl_n;
      smp_q  <= smp_n;
    end
  end

  // Bit clock and word select.
  logic bclk_q, ws_q, ws_n;
  assign ws_n = (fmt_q == FMT_RJ) ? ~right : right;

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      bclk_q <= 1'b0;
      ws_q   <= 1'b0;
    end else begin
      bclk_q <= cnt[PH_W-1];
      if (bit_en) ws_q <= ws_n;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sap_tx_lane #(
      .SMP_W(SMP_W), .SLOT_BITS(SLOT_BITS), .CTRL_W(CTRL_W), .USE_CTRL(g == 0)
    ) u_lane (
      .clk(clk), .rst_n(rst_i_n), .bit_en(bit_en), .pos(pos), .right(right),
      .fmt(fmt_q), .wsel(wsel_q),
      .smp_l(smp_q[(2*g)*SMP_W +: SMP_W]),
      .smp_r(smp_q[(2*g+1)*SMP_W +: SMP_W]),
      .ctrl(ctrl_q), .sd(sd_out[g])
    );
  end

  sap_rx #(.IN_W(IN_W), .SLOT_BITS(SLOT_BITS)) u_rx (
    .clk(clk), .rst_n(rst_i_n), .smp_en(mid_en), .pos(pos), .right(right),
    .fmt(fmt_q), .sd_in(sd_in), .frame_end(last),
    .rx_l(rx_left), .rx_r(rx_right), .valid(rx_valid)
  );

  assign bclk    = bclk_q;
  assign ws      = ws_q;
  assign tx_load = last;

endmodule

// File: rtl/serial_audio_port_chk.sv
module serial_audio_port_chk #(
  parameter int BIT_CLKS  = 16,
  parameter int SLOT_BITS = 32,
  parameter int LANES     = 2,
  localparam int FRAME    = 2 * SLOT_BITS * BIT_CLKS
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bclk,
  input logic             ws,
  input logic [LANES-1:0] sd_out,
  input logic             tx_load,
  input logic             rx_valid
);

  logic        prev_b, seen_b, seen_l;
  logic [15:0] run_b, run_l;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_b <= 1'b0;
      seen_b <= 1'b0;
      seen_l <= 1'b0;
      run_b  <= 16'd1;
      run_l  <= 16'd0;
    end else begin
      prev_b <= bclk;
      if (bclk != prev_b) begin
        if (seen_b) begin
          AST_BCLK_HALF: assert (run_b == 16'(BIT_CLKS / 2)) else $error("bclk half period %0d", run_b); // R2
        end
        seen_b <= 1'b1;
        run_b  <= 16'd1;
      end else begin
        run_b <= run_b + 16'd1;
      end
      if (tx_load) begin
        if (seen_l) begin
          AST_LOAD_SPACING: assert (run_l == 16'(FRAME - 1)) else $error("load spacing %0d", run_l); // R2
        end
        seen_l <= 1'b1;
        run_l  <= 16'd0;
      end else begin
        run_l <= run_l + 16'd1;
      end
    end
  end

  AST_SD_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n) !$stable(sd_out) |-> $fell(bclk)) else $error("data moved off bclk fall"); // R3
  AST_WS_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n) !$stable(ws) |-> $fell(bclk)) else $error("ws moved off bclk fall"); // R3
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n) rx_valid |=> !rx_valid) else $error("valid longer than one cycle"); // R10
  AST_VALID_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n) rx_valid |-> $past(tx_load)) else $error("valid without load"); // R10

endmodule

bind serial_audio_port serial_audio_port_chk #(
  .BIT_CLKS(BIT_CLKS), .SLOT_BITS(SLOT_BITS), .LANES(LANES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bclk(bclk), .ws(ws), .sd_out(sd_out),
  .tx_load(tx_load), .rx_valid(rx_valid)
);

// File: tb/sim_serial_audio_port.sv
`timescale 1ns/1ps
module sim_serial_audio_port;

  localparam int NFR = 9;

  typedef struct {
    logic        rj;
    logic [1:0]  sel;
    logic [15:0] ctrl;
    logic [79:0] smp;
    logic [15:0] rxl;
    logic [15:0] rxr;
  } frame_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fmt_rj;
  logic [1:0]  width_sel;
  logic [15:0] ctrl_word;
  logic [79:0] tx_samples;
  logic        sd_in;
  logic        bclk, ws, tx_load, rx_valid;
  logic [1:0]  sd_out;
  logic [15:0] rx_left, rx_right;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  serial_audio_port u0 (
    .clk(clk), .rst_n(rst_n), .fmt_rj(fmt_rj), .width_sel(width_sel),
    .ctrl_word(ctrl_word), .tx_samples(tx_samples), .sd_in(sd_in),
    .bclk(bclk), .ws(ws), .sd_out(sd_out), .tx_load(tx_load),
    .rx_left(rx_left), .rx_right(rx_right), .rx_valid(rx_valid)
  );

  frame_t q[$];

  task automatic check(input bit ok, input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  function automatic int wid(logic [1:0] sel);
    return (sel >= 2) ? 20 : 16 + 2 * int'(sel);
  endfunction

  function automatic logic [31:0] slot_exp(logic rj, logic [1:0] sel, logic [19:0] s, bit lane0, logic [15:0] c);
    int w;
    logic [31:0] top;
    w   = wid(sel);
    top = 32'(s >> (20 - w));
    if (!rj)   return top << (31 - w);
    if (lane0) return (32'(c >> (w - 16)) << w) | top;
    return ({32{s[19]}} << w) | top;
  endfunction

  function automatic logic [63:0] lane_exp(frame_t f, int lane);
    return {slot_exp(f.rj, f.sel, f.smp[(2*lane)*20 +: 20], lane == 0, f.ctrl),
            slot_exp(f.rj, f.sel, f.smp[(2*lane+1)*20 +: 20], lane == 0, f.ctrl)};
  endfunction

  function automatic logic rx_bit(frame_t f, int k);
    int p;
    logic [15:0] v;
    p = k % 32;
    v = (k >= 32) ? f.rxr : f.rxl;
    if (!f.rj && p >= 1 && p <= 16) return v[16 - p];
    if (f.rj && p >= 16)            return v[31 - p];
    return 1'(p + 1);
  endfunction

  function automatic frame_t make_vec(int i);
    frame_t f;
    f.rj   = 1'(i);
    f.sel  = 2'((i >> 1) % 4);
    f.ctrl = 16'(i * 32'h1357) ^ 16'hA5C3;
    for (int ch = 0; ch < 4; ch++) f.smp[ch*20 +: 20] = 20'((i * 4 + ch + 1) * 32'h9E3B5) ^ 20'(ch * 32'h80421);
    f.rxl  = 16'(i * 32'h3D1F + 32'h8001);
    f.rxr  = 16'(i * 32'h6B27) ^ 16'h4C3A;
    return f;
  endfunction

  task automatic apply(frame_t f);
    fmt_rj     = f.rj;
    width_sel  = f.sel;
    ctrl_word  = f.ctrl;
    tx_samples = f.smp;
  endtask

  // Driver: pushes the expected frame as it presents each vector for capture.
  initial begin
    frame_t f0, f;
    f0.rj = 1'b0; f0.sel = 2'd0; f0.ctrl = '0; f0.smp = '0;
    f0.rxl = 16'h1234; f0.rxr = 16'hBEEF;
    q.push_back(f0);
    fmt_rj = 1'b1; width_sel = 2'd3; ctrl_word = 16'hFFFF; tx_samples = {80{1'b1}};
    sd_in = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state at the ports
    check(bclk == 0 && ws == 0 && sd_out == 0 && rx_valid == 0 && rx_left == 0 && rx_right == 0,
          "R1 reset outputs", {28'd0, bclk, ws, sd_out, rx_valid, rx_left, rx_right}, 64'd0);
    rst_n = 1'b1;
    for (int i = 1; i < NFR; i++) begin
      do @(negedge clk); while (!tx_load);
      f = make_vec(i);
      apply(f);
      q.push_back(f);
      repeat (300) @(negedge clk);
      f.rj = ~f.rj; f.sel = ~f.sel; f.ctrl = ~f.ctrl; f.smp = ~f.smp;
      apply(f);  // R7: mid-frame changes must not reach the current frame
    end
  end

  // Monitor: rebuilds each frame from the serial outputs and compares it.
  int frames_done = 0, rx_done = 0, k = 0, cyc = 0, last_rise = -1, last_load = -1;
  int bad_sp = 0, bad_chg = 0;
  logic pb = 1'b0, pws = 1'b0, pld = 1'b0, have_pend = 1'b0;
  logic [1:0] psd = 2'b00;
  logic [63:0] cap0, cap1, capw;
  frame_t cur, pend;

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if ((sd_out != psd || ws != pws) && !(pb && !bclk)) bad_chg++;
      if (tx_load) begin
        if (last_load >= 0) check(cyc - last_load == 1024, "R2 load spacing", 64'(cyc - last_load), 64'd1024);
        last_load = cyc;
      end
      if (rx_valid && rx_done < NFR) begin
        check(pld == 1'b1, "R10 valid after load", 64'(pld), 64'd1);
        check(have_pend && rx_left == pend.rxl && rx_right == pend.rxr, "R9 R10 received samples",
              {32'd0, rx_left, rx_right}, {32'd0, pend.rxl, pend.rxr});
        rx_done++;
      end
      if (bclk && !pb && frames_done < NFR) begin
        if (last_rise >= 0 && cyc - last_rise != 16) bad_sp++;
        last_rise = cyc;
        if (k == 0) begin
          if (q.size() == 0) begin
            check(1'b0, "R7 frame queue empty", 64'd0, 64'd1);
          end else begin
            cur = q.pop_front();
          end
        end
        cap0[63-k] = sd_out[0];
        cap1[63-k] = sd_out[1];
        capw[63-k] = ws;
        if (k == 63) begin
          check(cap0 == lane_exp(cur, 0), cur.rj ? "R5 R6 R7 R8 lane0" : "R4 R6 R7 R8 lane0", cap0, lane_exp(cur, 0));
          check(cap1 == lane_exp(cur, 1), cur.rj ? "R5 R6 R7 R8 lane1" : "R4 R6 R7 R8 lane1", cap1, lane_exp(cur, 1));
          check(capw == (cur.rj ? {32'hFFFFFFFF, 32'h0} : {32'h0, 32'hFFFFFFFF}),
                cur.rj ? "R5 ws" : "R4 ws", capw, cur.rj ? {32'hFFFFFFFF, 32'h0} : {32'h0, 32'hFFFFFFFF});
          check(bad_sp == 0, "R2 bclk period", 64'(bad_sp), 64'd0);
          check(bad_chg == 0, "R3 change off falling edge", 64'(bad_chg), 64'd0);
          pend = cur;
          have_pend = 1'b1;
          frames_done++;
          k = 0;
        end else begin
          k++;
        end
        sd_in = (k == 0) ? 1'b1 : rx_bit(cur, k);
      end
      pb = bclk; pws = ws; psd = sd_out; pld = tx_load;
    end
  end

  initial begin
    int n = 0;
    while (!(frames_done >= NFR && rx_done >= NFR) && n < 150000) begin
      @(negedge clk);
      n++;
    end
    if (!(frames_done >= NFR && rx_done >= NFR)) check(1'b0, "R2 watchdog expired", 64'(frames_done), 64'(NFR));
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule